// File: doc/BRIEF.md
# Shift-Add Four-Tap FIR Filter

This block is a streaming four-tap finite impulse response filter with fixed coefficients. Samples arrive one per clock at most, each marked by a valid strobe. The filter keeps the last four accepted samples and forms their weighted sum without a single multiplier. Every coefficient product is built from shifted copies of the samples. Products with a negative coefficient are formed by subtracting the sign-bit term.

Samples that share coefficient bit positions are pre-added once. The even-indexed pair (newest sample and sample two back) is summed once. The odd-indexed pair (one back and three back) is summed the same way. The even pair sum is also tripled once, by adding it to itself shifted left by one. That tripled value then serves both pairs of adjacent low set bits (weights 1+2 and 16+32). The result is kept at full precision, with the binary point seven places above the least significant bit.

Control is a plain two-stage pipeline rather than a state machine. The two stages are an accept stage, which shifts the window, and a result stage, which registers the sum. A one-bit valid flag walks from one stage to the next.

Top module: `fir4_shiftadd`

## Requirements
- R1: With the newest accepted sample x0 and older samples x1, x2, x3, out_data equals 59·x0 + 43·x1 − 77·x2 − 54·x3 exactly. These integers are the coefficients 0.0111011, 0.0101011, 1.0110011 and 1.1001010 (two's complement, seven fraction bits), scaled by 128.
- R2: out_valid is high in exactly the cycles that follow, by two clock edges, an edge at which in_valid was high. out_data carries the result for that accepted sample.
- R3: The sample window advances only on edges where in_valid is high. Idle cycles between samples do not change any later result.
- R4: An active-low reset clears the whole window, out_data and out_valid to zero. The first result after reset treats all older samples as zero.
- R5: While out_valid is low, out_data keeps its last value.
- R6: out_data is SAMPLE_W+8 bits signed. It holds the extreme sums ±233·2^(SAMPLE_W−1) without wrapping.
- R7: A single sample of value 1 followed by zeros yields the successive outputs 59, 43, −77, −54, then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies in_sample for this cycle |
| in_sample | input | SAMPLE_W | Signed input sample |
| out_valid | output | 1 | Marks a new filter result on out_data |
| out_data | output | SAMPLE_W+8 | Signed full-precision result, 7 fraction bits |

## Verification
An impulse isolates each coefficient in turn. This separates a wrong shift position or a wrong pair assignment from a wrong sign. A mixed table of positive, negative and extreme samples, with idle gaps between them, exercises the shared pair sums under cancellation. It also shows whether gaps wrongly advance the window or disturb the held output. Alternating full-scale samples push the sum to both extremes and would expose any carry lost from the narrow intermediate terms. A reset in mid-stream shows whether old samples leak into the first result afterwards.

// File: rtl/fir4_pkg.sv
package fir4_pkg;
    // number of taps in the window
    localparam int NTAP    = 4;
    // growth bits: sum of |coefficient| is 233 < 2^8
    localparam int GUARD_W = 8;
    // edges from an accepted sample to its result
    localparam int LATENCY = 2;
endpackage

// File: rtl/fir4_tapline.sv
module fir4_tapline #(
    parameter int SAMPLE_W = 12,
    parameter int NTAP     = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           shift_en,
    input  logic [SAMPLE_W-1:0]            din,
    output logic [NTAP-1:0][SAMPLE_W-1:0]  window
);
    logic [NTAP-1:0][SAMPLE_W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q[0] <= '0;
        else if (shift_en)
            stage_q[0] <= din;
    end

    for (genvar g = 1; g < NTAP; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[g] <= '0;
            else if (shift_en)
                stage_q[g] <= stage_q[g-1];
        end
    end

    assign window = stage_q;
endmodule

// File: rtl/fir4_shiftadd_core.sv
module fir4_shiftadd_core #(
    parameter int SAMPLE_W = 12,
    parameter int NTAP     = 4,
    parameter int OUT_W    = 20
) (
    input  logic [NTAP-1:0][SAMPLE_W-1:0] window,
    output logic signed [OUT_W-1:0]       sum_y
);
    localparam int EXT_W = OUT_W - SAMPLE_W;

    logic signed [OUT_W-1:0] ext [NTAP];

    for (genvar g = 0; g < NTAP; g++) begin : g_ext
        assign ext[g] = {{EXT_W{window[g][SAMPLE_W-1]}}, window[g]};
    end

    logic signed [OUT_W-1:0] pair_even, pair_odd, even_x3;
    logic signed [OUT_W-1:0] even_part, odd_part;

    // pre-added pairs sharing coefficient bit positions
    assign pair_even = ext[0] + ext[2];
    assign pair_odd  = ext[1] + ext[3];
    // weight 3 built once, reused for bits {1,0} and {5,4}
    assign even_x3   = pair_even + (pair_even <<< 1);

    // 59*x0 - 77*x2 = 51*(x0+x2) + 8*x0 - 128*x2
    assign even_part = even_x3 + (even_x3 <<< 4) + (ext[0] <<< 3) - (ext[2] <<< 7);
    // 43*x1 - 54*x3 = 10*(x1+x3) + 33*x1 - 64*x3
    assign odd_part  = (pair_odd <<< 3) + (pair_odd <<< 1) + ext[1] + (ext[1] <<< 5)
                     - (ext[3] <<< 6);

    assign sum_y = even_part + odd_part;
endmodule

// File: rtl/fir4_shiftadd.sv
module fir4_shiftadd #(
    parameter  int SAMPLE_W = 12,
    localparam int OUT_W    = SAMPLE_W + fir4_pkg::GUARD_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [SAMPLE_W-1:0]        in_sample,
    output logic                       out_valid,
    output logic signed [OUT_W-1:0]    out_data
);
    localparam int NTAP = fir4_pkg::NTAP;

    logic [NTAP-1:0][SAMPLE_W-1:0] win;
    logic signed [OUT_W-1:0]       sum_comb;
    logic                          acc_vld_q;

    fir4_tapline #(.SAMPLE_W(SAMPLE_W), .NTAP(NTAP)) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .din      (in_sample),
        .window   (win)
    );

    fir4_shiftadd_core #(.SAMPLE_W(SAMPLE_W), .NTAP(NTAP), .OUT_W(OUT_W)) u_core (
        .window (win),
        .sum_y  (sum_comb)
    );

    // accept stage flag
    always_ff @(posedge clk) begin
        if (!rst_n) acc_vld_q <= 1'b0;
        else        acc_vld_q <= in_valid;
    end

    // result stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= acc_vld_q;
            if (acc_vld_q)
                out_data <= sum_comb;
        end
    end
endmodule

// File: rtl/fir4_shiftadd_chk.sv
module fir4_shiftadd_chk #(
    parameter int SAMPLE_W = 12,
    parameter int OUT_W    = 20
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_valid,
    input logic                         out_valid,
    input logic signed [OUT_W-1:0]      out_data,
    input logic [3:0][SAMPLE_W-1:0]     win
);
    // multiplier-based reference from the window contents
    logic signed [63:0] mul_ref;
    always_comb begin
        mul_ref = 64'($signed(win[0])) * 64'sd59
                + 64'($signed(win[1])) * 64'sd43
                - 64'($signed(win[2])) * 64'sd77
                - 64'($signed(win[3])) * 64'sd54;
    end

    a_r1_matches_multiply: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (64'(out_data) == $past(mul_ref)));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    a_r3_window_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(win));

    a_r4_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0 && win == '0));

    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));
endmodule

bind fir4_shiftadd fir4_shiftadd_chk #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .win       (win)
);

// File: tb/fir4_shiftadd_tb_top.sv
module fir4_shiftadd_tb_top;
    localparam int SW = 12;
    localparam int OW = SW + 8;
    localparam int NV = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [SW-1:0] in_sample = '0;
    logic out_valid;
    logic signed [OW-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model state
    longint hist [4];
    longint last_out;
    bit     pv [2];
    longint pd [2];

    // stimulus table: {valid, sample}
    localparam logic [SW:0] VEC [NV] = '{
        {1'b1, 12'sd5},    {1'b1, -12'sd3},   {1'b0, 12'sd999},  {1'b1, 12'sd100},
        {1'b1, 12'sd2047}, {1'b0, -12'sd7},   {1'b0, 12'sd44},   {1'b1, -12'sd2048},
        {1'b1, 12'sd1},    {1'b1, -12'sd1},   {1'b1, 12'sd777},  {1'b0, 12'sd0},
        {1'b1, -12'sd1234},{1'b1, 12'sd321},  {1'b1, 12'sd0},    {1'b1, -12'sd600},
        {1'b1, 12'sd1500}, {1'b0, 12'sd1500}, {1'b1, 12'sd63},   {1'b1, -12'sd64}
    };

    fir4_shiftadd #(.SAMPLE_W(SW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #4 clk = ~clk;

    task automatic model_clear();
        for (int i = 0; i < 4; i++) hist[i] = 0;
        last_out = 0;
        pv[0] = 1'b0; pv[1] = 1'b0;
        pd[0] = 0;    pd[1] = 0;
    endtask

    task automatic check(string tag, bit ev, longint ed);
        n_chk++;
        if (out_valid !== ev || longint'(out_data) != ed) begin
            n_bad++;
            $display("FAIL %s: out_valid=%0b out_data=%0d expected out_valid=%0b out_data=%0d",
                     tag, out_valid, out_data, ev, ed);
        end
    endtask

    // one cycle: compare outputs, then drive the next input
    task automatic step(string tag, bit v, logic [SW-1:0] s);
        @(negedge clk);
        check(tag, pv[1], pd[1]);
        in_valid  = v;
        in_sample = s;
        pv[1] = pv[0];
        pd[1] = pd[0];
        if (v) begin
            for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = longint'($signed(s));
            last_out = 59*hist[0] + 43*hist[1] - 77*hist[2] - 54*hist[3];
        end
        pv[0] = v;
        pd[0] = last_out;
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(tag, 1'b0, 0);
        rst_n = 1'b1;
        model_clear();
    endtask

    initial begin
        model_clear();
        do_reset("R4 reset state");

        // R7: impulse response
        step("R7 impulse", 1'b1, 12'sd1);
        for (int i = 0; i < 5; i++) step("R7 impulse", 1'b1, 12'sd0);
        step("R7 flush", 1'b0, 12'sd0);
        step("R7 flush", 1'b0, 12'sd0);

        // R1 R2 R3 R5: table with idle gaps
        for (int i = 0; i < NV; i++) step("R1/R3/R5 table", VEC[i][SW], VEC[i][SW-1:0]);
        step("R2 flush", 1'b0, 12'sd0);
        step("R2 flush", 1'b0, 12'sd0);

        // R6: extreme positive then extreme negative sums
        step("R6 max", 1'b1, -12'sd2048);
        step("R6 max", 1'b1, -12'sd2048);
        step("R6 max", 1'b1, 12'sd2047);
        step("R6 max", 1'b1, 12'sd2047);
        step("R6 min", 1'b1, -12'sd2048);
        step("R6 min", 1'b1, -12'sd2048);
        step("R6 min", 1'b1, 12'sd2047);
        step("R6 min", 1'b1, -12'sd2048);
        step("R6 min", 1'b1, -12'sd2048);
        step("R6 flush", 1'b0, 12'sd0);
        step("R6 flush", 1'b0, 12'sd0);

        // R4: reset mid-stream, first result must see zero history
        step("R4 prefill", 1'b1, 12'sd900);
        step("R4 prefill", 1'b1, -12'sd900);
        do_reset("R4 mid-stream reset");
        step("R4 after reset", 1'b1, 12'sd10);
        step("R4 after reset", 1'b0, 12'sd0);
        step("R4 after reset", 1'b0, 12'sd0);
        step("R5 hold", 1'b0, 12'sd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule